// File: doc/BRIEF.md
# FSK Character Buffer with Host Shift-Out Port

This block sits between the recovered bit stream of an FSK demodulator and a host microcontroller. A mode input chooses how the host sees the data. In direct mode, the raw demodulated stream is copied to the data output. In buffered mode, the block frames each asynchronous character at 1200 bit/s. It drops the start bit, keeps the eight data bits and the stop bit, and pulls a data-ready line low. The host then clocks the character out with its own shift clock.

Framing runs from a counter derived from the system clock, which defaults to 3.579545 MHz. A character is one low start bit, eight data bits sent least significant first, and a stop bit that should be high. The start bit is confirmed half a bit period after the falling edge, and each later bit is sampled near its centre. The host shift clock is asynchronous, so it passes through a two-flop synchronizer, and only its rising edge acts. One combination of the control inputs puts the block into a power-down state.

Top module: `fsk_word_port`

## Requirements
- R1: With `mode_buf` low, `dout` follows `rx_bit` combinationally and `rdy_n` stays high.
- R2: With `mode_buf` low, pulses on `sclk` have no effect. A character held from buffered mode keeps its data, and it reads out unchanged once buffered mode returns.
- R3: In buffered mode, `rdy_n` goes low once the stop bit of a character has been sampled.
- R4: Shift pulses 1 to 8 after a character place data bits 0 to 7 on `dout`, bit 0 being the first bit received, one bit per rising edge of `sclk`.
- R5: The ninth shift pulse places the stored stop bit on `dout`, so a stop bit of 0 reads back as 0 and shows a framing error.
- R6: `rdy_n` returns high on the first rising edge of `sclk` after it went low.
- R7: `rdy_n` returns high when the falling edge of a following start bit is detected, even if no shift pulse came.
- R8: A low pulse on `rx_bit` that has ended by the middle of a bit period does not start a character. No data-ready follows it.
- R9: With `mode_buf` high and `ctl_a` and `ctl_b` both low, the block is powered down. `dout` and `rdy_n` are held at 1, and any character arriving in that state is not received.
- R10: After reset in buffered mode, `rdy_n` is 1 and `dout` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_buf | input | 1 | 0 selects direct mode, 1 selects buffered mode |
| ctl_a | input | 1 | Control bit; used only in the power-down decode |
| ctl_b | input | 1 | Control bit; used only in the power-down decode |
| rx_bit | input | 1 | Demodulated serial bit stream (idle high) |
| sclk | input | 1 | Host shift clock, asynchronous |
| dout | output | 1 | Serial data to the host |
| rdy_n | output | 1 | Data ready, active low |

## Verification
In direct mode and in power-down, `dout` is combinational. The bench therefore checks it on the next falling clock edge after it drives the inputs. A rising edge on `sclk` reaches `dout` and `rdy_n` on the third rising clock edge: two synchronizer stages, then the output register. Each shift pulse is therefore held for three clock cycles, and the outputs are sampled on the falling edge that follows. A character completes about half a bit before the end of its stop bit. Data-ready is checked a few cycles after the stop-bit period, and a start-bit release is checked four cycles after the falling edge.

// File: rtl/fsk_word_port.sv
module fsk_word_port #(
  parameter int CLK_HZ    = 3579545,
  parameter int BAUD_RATE = 1200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_buf,
  input  logic ctl_a,
  input  logic ctl_b,
  input  logic rx_bit,
  input  logic sclk,
  output logic dout,
  output logic rdy_n
);
  localparam int BIT_CYC = CLK_HZ / BAUD_RATE;
  localparam int HALF    = BIT_CYC / 2;
  localparam int CW      = $clog2(BIT_CYC + 1);
  localparam logic [1:0] S_IDLE = 2'd0, S_START = 2'd1, S_DATA = 2'd2;

  logic       pd, run;
  logic [2:0] rxs, cks;
  logic [1:0] st;
  logic [CW-1:0] cnt;
  logic [3:0] nbit;
  logic [8:0] sh, osr;
  logic       q, rdy_r;
  logic       line, start_edge, sclk_rise, word_done;

  assign pd         = mode_buf & ~ctl_a & ~ctl_b;
  assign run        = mode_buf & ~pd;
  assign line       = rxs[1];
  assign start_edge = rxs[2] & ~rxs[1];
  assign sclk_rise  = cks[1] & ~cks[2];
  assign word_done  = run && st == S_DATA && cnt == CW'(BIT_CYC - 1) && nbit == 4'd8;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rxs <= 3'b111;
      cks <= 3'b000;
    end else begin
      rxs <= {rxs[1:0], rx_bit};
      cks <= {cks[1:0], sclk};
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st   <= S_IDLE;
      cnt  <= '0;
      nbit <= '0;
      sh   <= '1;
    end else if (!run) begin
      st   <= S_IDLE;
      cnt  <= '0;
      nbit <= '0;
    end else begin
      case (st)
        S_IDLE:
          if (start_edge) begin
            st  <= S_START;
            cnt <= '0;
          end
        S_START:
          if (cnt == CW'(HALF - 1)) begin
            cnt  <= '0;
            nbit <= '0;
            st   <= line ? S_IDLE : S_DATA;
          end else cnt <= cnt + 1'b1;
        S_DATA:
          if (cnt == CW'(BIT_CYC - 1)) begin
            cnt  <= '0;
            sh   <= {line, sh[8:1]};
            nbit <= nbit + 1'b1;
            if (nbit == 4'd8) st <= S_IDLE;
          end else cnt <= cnt + 1'b1;
        default: st <= S_IDLE;
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      osr   <= '1;
      q     <= 1'b1;
      rdy_r <= 1'b1;
    end else if (word_done) begin
      osr   <= {line, sh[8:1]};
      rdy_r <= 1'b0;
    end else if (run) begin
      if (sclk_rise) begin
        q   <= osr[0];
        osr <= {1'b1, osr[8:1]};
      end
      if (sclk_rise || (st == S_IDLE && start_edge)) rdy_r <= 1'b1;
    end

  assign dout  = !mode_buf ? rx_bit : (pd ? 1'b1 : q);
  assign rdy_n = ~run | rdy_r;
endmodule

module fsk_word_port_chk (
  input logic clk,
  input logic rst_n,
  input logic mode_buf,
  input logic ctl_a,
  input logic ctl_b,
  input logic rx_bit,
  input logic dout,
  input logic rdy_n,
  input logic sclk_rise,
  input logic start_edge,
  input logic run,
  input logic [1:0] st
);
  a_r1_direct_pass: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_buf |-> dout == rx_bit);
  a_r1_direct_rdy: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_buf |-> rdy_n);
  a_r9_pd_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_buf && !ctl_a && !ctl_b) |-> (dout && rdy_n));
  a_r6_rdy_release: assert property (@(posedge clk) disable iff (!rst_n)
    (run && sclk_rise) |=> rdy_n);
  a_r7_start_release: assert property (@(posedge clk) disable iff (!rst_n)
    (run && st == 2'd0 && start_edge) |=> rdy_n);
endmodule

bind fsk_word_port fsk_word_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mode_buf(mode_buf), .ctl_a(ctl_a), .ctl_b(ctl_b),
  .rx_bit(rx_bit), .dout(dout), .rdy_n(rdy_n), .sclk_rise(sclk_rise),
  .start_edge(start_edge), .run(run), .st(st)
);

// File: tb/tb_fsk_word_port.sv
module tb_fsk_word_port;
  localparam int BIT = 16;
  logic clk = 0, rst_n = 0;
  logic mode_buf = 1, ctl_a = 1, ctl_b = 0, rx_bit = 1, sclk = 0;
  logic dout, rdy_n;
  int checks = 0, failures = 0;

  fsk_word_port #(.CLK_HZ(BIT), .BAUD_RATE(1)) dut (
    .clk(clk), .rst_n(rst_n), .mode_buf(mode_buf), .ctl_a(ctl_a), .ctl_b(ctl_b),
    .rx_bit(rx_bit), .sclk(sclk), .dout(dout), .rdy_n(rdy_n));

  always #4 clk = ~clk;

  localparam logic [8:0] VEC [8] = '{9'h1A5, 9'h100, 9'h1FF, 9'h15A,
                                     9'h0C3, 9'h181, 9'h13C, 9'h07E};

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic send_char(input logic [8:0] w, input bit probe);
    @(negedge clk) rx_bit = 0;
    if (probe) begin
      repeat (4) @(negedge clk);
      check("R7 start releases ready", rdy_n, 1'b1);
      repeat (BIT - 4) @(negedge clk);
    end else repeat (BIT) @(negedge clk);
    for (int i = 0; i < 9; i++) begin
      rx_bit = w[i];
      repeat (BIT) @(negedge clk);
    end
    rx_bit = 1;
    repeat (4) @(negedge clk);
  endtask

  task automatic pulse();
    sclk = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic unpulse();
    sclk = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic read_all(input logic [8:0] w);
    for (int k = 0; k < 9; k++) begin
      pulse();
      if (k < 8) check("R4 data bit", dout, w[k]);
      else check("R5 stop bit", dout, w[8]);
      if (k == 0) check("R6 ready released by shift", rdy_n, 1'b1);
      unpulse();
    end
  endtask

  initial begin
    #(8 * 200000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R10 reset rdy_n", rdy_n, 1'b1);
    check("R10 reset dout", dout, 1'b1);

    foreach (VEC[v]) begin
      send_char(VEC[v], 0);
      check("R3 ready after char", rdy_n, 1'b0);
      read_all(VEC[v]);
    end

    send_char(9'h1C6, 0);
    @(negedge clk) mode_buf = 0;
    rx_bit = 0;
    @(negedge clk);
    check("R1 direct low", dout, 1'b0);
    check("R1 direct ready high", rdy_n, 1'b1);
    rx_bit = 1;
    @(negedge clk);
    check("R1 direct high", dout, 1'b1);
    for (int i = 0; i < 3; i++) begin pulse(); unpulse(); end
    mode_buf = 1;
    @(negedge clk);
    check("R2 ready kept", rdy_n, 1'b0);
    pulse();
    check("R2 first bit kept", dout, 1'b0);
    unpulse();
    pulse();
    check("R2 second bit kept", dout, 1'b1);
    unpulse();

    send_char(9'h133, 0);
    check("R3 ready before R7", rdy_n, 1'b0);
    send_char(9'h1E4, 1);
    check("R3 second ready", rdy_n, 1'b0);
    read_all(9'h1E4);

    @(negedge clk) rx_bit = 0;
    repeat (3) @(negedge clk);
    rx_bit = 1;
    repeat (12 * BIT) @(negedge clk);
    check("R8 glitch ignored", rdy_n, 1'b1);
    send_char(9'h169, 0);
    check("R8 clean char after glitch", rdy_n, 1'b0);
    pulse();
    check("R8 first bit after glitch", dout, 1'b1);
    unpulse();

    send_char(9'h1AA, 0);
    ctl_a = 0;
    @(negedge clk);
    check("R9 pd ready", rdy_n, 1'b1);
    check("R9 pd dout", dout, 1'b1);
    send_char(9'h155, 0);
    check("R9 pd dout after char", dout, 1'b1);
    ctl_a = 1;
    repeat (2) @(negedge clk);
    pulse();
    check("R9 old word kept", dout, 1'b0);
    unpulse();
    pulse();
    check("R9 old word bit1", dout, 1'b1);
    unpulse();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule